// File: doc/BRIEF.md
# Flash Verify-After-Program Command Sequencer

This block carries out the read-back check that follows programming of one 32-bit word in an embedded flash array. Software supplies a byte address, a margin-choice code, four expected data bytes and a permission bit, then starts the command by clearing the completion flag. The launch is a one-cycle pulse on `cmd_launch`. The block first checks that the command is legal. If it is, the block reads the addressed word twice through a simple array read port, each time comparing the returned word with the expected bytes. The first read uses the sense margin for ones and the second uses the sense margin for zeros.

Any illegal command sets the access-error flag right away and issues no array read. A legal command ends with a single margin-status flag, which is the OR of the two comparison results. The read port is a request/valid handshake, so the block holds no fixed latency and waits for each valid.

Top module: `pgmchk_seq`

## Requirements
- R1: After reset, `done_flag` is 1, `acc_err` and `mgn_fail` are 0 and `rd_req` is 0.
- R2: A `cmd_launch` pulse seen while `done_flag` is 1 starts a command: in the next cycle `done_flag`, `acc_err` and `mgn_fail` are all 0. A pulse seen while `done_flag` is 0 is ignored and changes neither the running command nor its result.
- R3: If address bits [1:0] are not 00, the command sets `acc_err`, issues no read and leaves `mgn_fail` at 0.
- R4: Margin code 0x01 drives `rd_level` = 0 (user) and code 0x02 drives `rd_level` = 1 (factory) on both reads. Every other code sets `acc_err` and issues no read.
- R5: An address at or above `FLASH_BYTES`, or `cmd_allowed` = 0 at launch, sets `acc_err` and issues no read. The last aligned word below `FLASH_BYTES` is legal.
- R6: A legal command issues exactly two one-cycle `rd_req` pulses, both with `rd_word_addr` = address bits [ADDR_W-1:2]. The first has `rd_pol` = 0 (ones margin). The second has `rd_pol` = 1 (zeros margin) and comes only after the first `rd_valid`.
- R7: The expected word is little-endian, {`exp_b3`,`exp_b2`,`exp_b1`,`exp_b0`}. `mgn_fail` is set at completion exactly when the data of either read differs from it.
- R8: On an access error, `done_flag` and `acc_err` both rise on the clock edge after the launch edge. On a legal command, `done_flag` rises on the edge that accepts the second `rd_valid`. `done_flag` stays 1 until the next accepted launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_launch | input | 1 | One-cycle command start (software clearing the completion flag) |
| cmd_addr | input | ADDR_W | Byte address of the word to verify |
| cmd_margin | input | 8 | Margin-choice code |
| cmd_allowed | input | 1 | Mode/security permits the command |
| exp_b0 | input | 8 | Expected byte at start address |
| exp_b1 | input | 8 | Expected byte at start address + 1 |
| exp_b2 | input | 8 | Expected byte at start address + 2 |
| exp_b3 | input | 8 | Expected byte at start address + 3 |
| done_flag | output | 1 | Completion flag, high when idle |
| acc_err | output | 1 | Access-error flag |
| mgn_fail | output | 1 | Margin-status flag |
| rd_req | output | 1 | Array read request pulse |
| rd_word_addr | output | ADDR_W-2 | Array word address |
| rd_level | output | 1 | Margin level: 0 user, 1 factory |
| rd_pol | output | 1 | Margin polarity: 0 ones, 1 zeros |
| rd_valid | input | 1 | Array read data valid |
| rd_data | input | 32 | Array read data |

## Verification
The bench builds the block with ADDR_W = 12 and FLASH_BYTES = 3072. Because that range is not a power of two, addresses above the array can be reached, and so can the last legal word just below the limit. The array model answers each request three cycles later. This gives enough time to inject a second launch while a read is outstanding. The model also applies separate bit-flip masks to the ones read and the zeros read, so a mismatch on either read alone can be produced.

// File: rtl/pgmchk_pkg.sv
package pgmchk_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int OFS_W      = $clog2(WORD_BYTES);

  localparam logic [7:0] MCODE_USER    = 8'h01;
  localparam logic [7:0] MCODE_FACTORY = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RD1   = 2'd2,
    ST_RD0   = 2'd3
  } pc_state_e;

  typedef enum logic {
    LVL_USER    = 1'b0,
    LVL_FACTORY = 1'b1
  } mlevel_e;

  typedef enum logic {
    POL_ONES  = 1'b0,
    POL_ZEROS = 1'b1
  } mpol_e;

  typedef struct packed {
    logic align_bad;
    logic range_bad;
    logic code_bad;
    logic mode_bad;
  } pc_fault_t;
endpackage

// File: rtl/pgmchk_rst_sync.sv
module pgmchk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pgmchk_legal.sv
module pgmchk_legal
  import pgmchk_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int FLASH_BYTES = 131072
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        mcode,
  input  logic              allowed,
  output pc_fault_t         fault,
  output logic              any_fault,
  output mlevel_e           level
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(FLASH_BYTES);

  logic code_user, code_fact;

  assign code_user = (mcode == MCODE_USER);
  assign code_fact = (mcode == MCODE_FACTORY);

  always_comb begin
    fault.align_bad = |addr[OFS_W-1:0];
    fault.range_bad = ({1'b0, addr} >= LIMIT);
    fault.code_bad  = !(code_user || code_fact);
    fault.mode_bad  = !allowed;
  end

  assign any_fault = |fault;
  assign level     = code_fact ? LVL_FACTORY : LVL_USER;
endmodule

// File: rtl/pgmchk_cmp.sv
module pgmchk_cmp
  import pgmchk_pkg::*;
(
  input  logic [WORD_BYTES-1:0][BYTE_W-1:0] exp_bytes,
  input  logic [WORD_W-1:0]                 rd_data,
  output logic                              mismatch
);
  logic [WORD_W-1:0]     exp_word;
  logic [WORD_BYTES-1:0] lane_diff;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    // byte g sits at byte offset g from the start address
    assign exp_word[g*BYTE_W +: BYTE_W] = exp_bytes[g];
    assign lane_diff[g] = |(exp_word[g*BYTE_W +: BYTE_W] ^ rd_data[g*BYTE_W +: BYTE_W]);
  end

  assign mismatch = |lane_diff;
endmodule

// File: rtl/pgmchk_seq.sv
module pgmchk_seq
  import pgmchk_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int FLASH_BYTES = 131072
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_launch,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [7:0]            cmd_margin,
  input  logic                  cmd_allowed,
  input  logic [7:0]            exp_b0,
  input  logic [7:0]            exp_b1,
  input  logic [7:0]            exp_b2,
  input  logic [7:0]            exp_b3,
  output logic                  done_flag,
  output logic                  acc_err,
  output logic                  mgn_fail,
  output logic                  rd_req,
  output logic [ADDR_W-3:0]     rd_word_addr,
  output logic                  rd_level,
  output logic                  rd_pol,
  input  logic                  rd_valid,
  input  logic [31:0]           rd_data
);
  logic rst_sync_n;

  pc_state_e state_q, state_d;
  logic done_q, done_d;
  logic err_q, err_d;
  logic fail_q, fail_d;
  logic req_q, req_d;
  logic mis1_q, mis1_d;
  mpol_e pol_q, pol_d;
  mlevel_e lvl_q, lvl_d;
  logic cap_en;

  logic [ADDR_W-1:0]                 addr_q;
  logic [7:0]                        code_q;
  logic                              allow_q;
  logic [WORD_BYTES-1:0][BYTE_W-1:0] exp_q;

  pc_fault_t fault;
  logic      any_fault;
  mlevel_e   level;
  logic      mismatch;

  pgmchk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pgmchk_legal #(.ADDR_W(ADDR_W), .FLASH_BYTES(FLASH_BYTES)) u_legal (
    .addr      (addr_q),
    .mcode     (code_q),
    .allowed   (allow_q),
    .fault     (fault),
    .any_fault (any_fault),
    .level     (level)
  );

  pgmchk_cmp u_cmp (
    .exp_bytes (exp_q),
    .rd_data   (rd_data),
    .mismatch  (mismatch)
  );

  // command capture, enabled only for an accepted launch
  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q   <= cmd_addr;
      code_q   <= cmd_margin;
      allow_q  <= cmd_allowed;
      exp_q[0] <= exp_b0;
      exp_q[1] <= exp_b1;
      exp_q[2] <= exp_b2;
      exp_q[3] <= exp_b3;
    end
  end

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    err_d   = err_q;
    fail_d  = fail_q;
    req_d   = 1'b0;
    mis1_d  = mis1_q;
    pol_d   = pol_q;
    lvl_d   = lvl_q;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_launch) begin
          cap_en  = 1'b1;
          done_d  = 1'b0;
          err_d   = 1'b0;
          fail_d  = 1'b0;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (any_fault) begin
          err_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          req_d   = 1'b1;
          pol_d   = POL_ONES;
          lvl_d   = level;
          mis1_d  = 1'b0;
          state_d = ST_RD1;
        end
      end
      ST_RD1: begin
        if (rd_valid) begin
          mis1_d  = mismatch;
          req_d   = 1'b1;
          pol_d   = POL_ZEROS;
          state_d = ST_RD0;
        end
      end
      ST_RD0: begin
        if (rd_valid) begin
          fail_d  = mis1_q | mismatch;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
      err_q   <= 1'b0;
      fail_q  <= 1'b0;
      req_q   <= 1'b0;
      mis1_q  <= 1'b0;
      pol_q   <= POL_ONES;
      lvl_q   <= LVL_USER;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      fail_q  <= fail_d;
      req_q   <= req_d;
      mis1_q  <= mis1_d;
      pol_q   <= pol_d;
      lvl_q   <= lvl_d;
    end
  end

  assign done_flag    = done_q;
  assign acc_err      = err_q;
  assign mgn_fail     = fail_q;
  assign rd_req       = req_q;
  assign rd_word_addr = addr_q[ADDR_W-1:OFS_W];
  assign rd_level     = lvl_q;
  assign rd_pol       = pol_q;
endmodule

// File: rtl/pgmchk_chk.sv
module pgmchk_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_launch,
  input logic done_flag,
  input logic acc_err,
  input logic mgn_fail,
  input logic rd_req,
  input logic rd_valid
);
  assert_launch_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_launch && done_flag) |=> (!done_flag && !acc_err && !mgn_fail));

  assert_err_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !rd_req);

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_no_req_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |-> !rd_req);

  assert_fail_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mgn_fail) |-> (done_flag && $past(rd_valid)));

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_err) |-> done_flag);

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !cmd_launch) |=> done_flag);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_err && mgn_fail));
endmodule

bind pgmchk_seq pgmchk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cmd_launch (cmd_launch),
  .done_flag  (done_flag),
  .acc_err    (acc_err),
  .mgn_fail   (mgn_fail),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid)
);

// File: tb/pgmchk_seq_tb_top.sv
module pgmchk_seq_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 12;
  localparam int FLASH_BYTES = 3072;
  localparam int RD_LAT      = 3;
  localparam int WD_CYCLES   = 50000;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_launch, cmd_allowed;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0] cmd_margin, exp_b0, exp_b1, exp_b2, exp_b3;
  logic done_flag, acc_err, mgn_fail, rd_req, rd_level, rd_pol, rd_valid;
  logic [ADDR_W-3:0] rd_word_addr;
  logic [31:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgmchk_seq #(.ADDR_W(ADDR_W), .FLASH_BYTES(FLASH_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_launch(cmd_launch), .cmd_addr(cmd_addr),
    .cmd_margin(cmd_margin), .cmd_allowed(cmd_allowed),
    .exp_b0(exp_b0), .exp_b1(exp_b1), .exp_b2(exp_b2), .exp_b3(exp_b3),
    .done_flag(done_flag), .acc_err(acc_err), .mgn_fail(mgn_fail),
    .rd_req(rd_req), .rd_word_addr(rd_word_addr), .rd_level(rd_level),
    .rd_pol(rd_pol), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // array model state and request log
  logic [31:0] flip_ones, flip_zeros;
  int rq_n;
  logic lg_pol [2];
  logic lg_lvl [2];
  logic [ADDR_W-3:0] lg_addr [2];

  // scoreboard queues
  bit q_err [$];
  bit q_fail [$];
  int q_nrd [$];
  bit q_lvl [$];
  logic [ADDR_W-3:0] q_wa [$];
  string q_tag [$];

  function automatic logic [31:0] base_word(input logic [ADDR_W-3:0] wa);
    logic [7:0] w;
    w = wa[7:0];
    return {w ^ 8'h5A, w, 8'hC3, ~w};
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // array read-port model
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    @(negedge clk);
    forever begin
      if (rd_req) begin
        logic pol;
        logic [ADDR_W-3:0] wa;
        pol = rd_pol;
        wa  = rd_word_addr;
        if (rq_n < 2) begin
          lg_pol[rq_n]  = rd_pol;
          lg_lvl[rq_n]  = rd_level;
          lg_addr[rq_n] = rd_word_addr;
        end
        rq_n++;
        repeat (RD_LAT-1) @(negedge clk);
        rd_data  = base_word(wa) ^ (pol ? flip_zeros : flip_ones);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // monitor: pops one expected item per completion
  initial begin
    logic prev_done;
    prev_done = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && done_flag && !prev_done) begin
        if (q_tag.size() == 0) begin
          chk("R2 unexpected completion", 32'd1, 32'd0);
        end else begin
          string t;
          bit e_err, e_fail, e_lvl;
          int e_nrd;
          logic [ADDR_W-3:0] e_wa;
          t = q_tag.pop_front();
          e_err = q_err.pop_front();
          e_fail = q_fail.pop_front();
          e_nrd = q_nrd.pop_front();
          e_lvl = q_lvl.pop_front();
          e_wa = q_wa.pop_front();
          chk({t, " access error flag"}, 32'(acc_err), 32'(e_err));
          chk({t, " R7 margin status"}, 32'(mgn_fail), 32'(e_fail));
          chk({t, " R6 read count"}, 32'(rq_n), 32'(e_nrd));
          if (e_nrd == 2 && rq_n == 2) begin
            chk({t, " R6 first read ones margin"}, 32'(lg_pol[0]), 32'd0);
            chk({t, " R6 second read zeros margin"}, 32'(lg_pol[1]), 32'd1);
            chk({t, " R4 level read 1"}, 32'(lg_lvl[0]), 32'(e_lvl));
            chk({t, " R4 level read 2"}, 32'(lg_lvl[1]), 32'(e_lvl));
            chk({t, " R6 word address read 1"}, 32'(lg_addr[0]), 32'(e_wa));
            chk({t, " R6 word address read 2"}, 32'(lg_addr[1]), 32'(e_wa));
          end
        end
      end
      prev_done = done_flag;
    end
  end

  // driver: issue one command and push its expected outcome
  task automatic run_cmd(input string tag, input logic [ADDR_W-1:0] addr,
                         input logic [7:0] code, input logic allow,
                         input logic [31:0] expw, input logic [31:0] fo,
                         input logic [31:0] fz, input bit poke);
    bit e_err, e_fail;
    logic [31:0] bw;
    e_err = (addr[1:0] != 2'b00) || (int'(addr) >= FLASH_BYTES) ||
            !(code == 8'h01 || code == 8'h02) || !allow;
    bw = base_word(addr[ADDR_W-1:2]);
    e_fail = !e_err && (((bw ^ fo) != expw) || ((bw ^ fz) != expw));
    q_tag.push_back(tag);
    q_err.push_back(e_err);
    q_fail.push_back(e_fail);
    q_nrd.push_back(e_err ? 0 : 2);
    q_lvl.push_back(code == 8'h02);
    q_wa.push_back(addr[ADDR_W-1:2]);
    flip_ones = fo;
    flip_zeros = fz;
    rq_n = 0;
    cmd_addr = addr;
    cmd_margin = code;
    cmd_allowed = allow;
    exp_b0 = expw[7:0];
    exp_b1 = expw[15:8];
    exp_b2 = expw[23:16];
    exp_b3 = expw[31:24];
    cmd_launch = 1'b1;
    @(negedge clk);
    cmd_launch = 1'b0;
    chk({tag, " R2 done cleared at launch"}, 32'(done_flag), 32'd0);
    chk({tag, " R2 flags cleared at launch"}, {30'd0, acc_err, mgn_fail}, 32'd0);
    if (poke) begin
      cmd_launch = 1'b1;
      cmd_margin = 8'h07;
      cmd_addr = addr + 1'b1;
      @(negedge clk);
      cmd_launch = 1'b0;
    end else if (e_err) begin
      @(negedge clk);
      chk({tag, " R8 error completes next cycle"}, {30'd0, done_flag, acc_err}, 32'd3);
    end
    while (!done_flag) @(negedge clk);
    repeat (6) @(negedge clk);
    if (poke) begin
      chk({tag, " R2 busy launch gave no extra completion"}, 32'(q_tag.size()), 32'd0);
      chk({tag, " R2 busy launch gave no extra reads"}, 32'(rq_n), 32'd2);
      chk({tag, " R2 busy launch left done set"}, 32'(done_flag), 32'd1);
    end
  endtask

  // watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w40, w44, wlast;
    rst_n = 1'b0;
    cmd_launch = 1'b0;
    cmd_addr = '0;
    cmd_margin = '0;
    cmd_allowed = 1'b0;
    exp_b0 = '0; exp_b1 = '0; exp_b2 = '0; exp_b3 = '0;
    flip_ones = '0;
    flip_zeros = '0;
    rq_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", 32'(done_flag), 32'd1);
    chk("R1 flags after reset", {30'd0, acc_err, mgn_fail}, 32'd0);
    chk("R1 no request after reset", 32'(rd_req), 32'd0);

    w40 = base_word(10'h010);
    w44 = base_word(10'h011);
    wlast = base_word(10'(FLASH_BYTES/4 - 1));

    run_cmd("R4 user margin match", 12'h040, 8'h01, 1'b1, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R4 factory margin match", 12'h044, 8'h02, 1'b1, w44, 32'h0, 32'h0, 1'b0);
    run_cmd("R7 ones read mismatch", 12'h040, 8'h01, 1'b1, w40, 32'h0000_0100, 32'h0, 1'b0);
    run_cmd("R7 zeros read mismatch", 12'h044, 8'h02, 1'b1, w44, 32'h0, 32'h8000_0000, 1'b0);
    run_cmd("R7 byte order reversed", 12'h040, 8'h01, 1'b1, bswap(w40), 32'h0, 32'h0, 1'b0);
    run_cmd("R3 misaligned by 2", 12'h042, 8'h01, 1'b1, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R3 misaligned by 1", 12'h045, 8'h02, 1'b1, w44, 32'h0, 32'h0, 1'b0);
    run_cmd("R4 code 0x00", 12'h040, 8'h00, 1'b1, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R4 code 0x03", 12'h040, 8'h03, 1'b1, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R4 code 0x81", 12'h040, 8'h81, 1'b1, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R5 address at limit", 12'(FLASH_BYTES), 8'h01, 1'b1, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R5 address near top", 12'hFFC, 8'h02, 1'b1, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R5 last legal word", 12'(FLASH_BYTES - 4), 8'h02, 1'b1, wlast, 32'h0, 32'h0, 1'b0);
    run_cmd("R5 not permitted", 12'h040, 8'h01, 1'b0, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R2 launch after error", 12'h044, 8'h01, 1'b1, w44, 32'h0, 32'h0, 1'b0);
    run_cmd("R7 mismatch before error", 12'h040, 8'h01, 1'b1, w40, 32'h1, 32'h1, 1'b0);
    run_cmd("R2 launch after mismatch", 12'h040, 8'h02, 1'b1, w40, 32'h0, 32'h0, 1'b0);
    run_cmd("R2 launch while busy", 12'h044, 8'h01, 1'b1, w44, 32'h0, 32'h0, 1'b1);
    run_cmd("R2 launch while busy fail", 12'h040, 8'h02, 1'b1, w40, 32'h0, 32'h10, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule